// File: doc/BRIEF.md
# DMA Descriptor Chain Reload Unit

When a DMA channel finishes a block, this unit refills the channel address and count registers from a queued descriptor. The CPU does not have to reprogram them. It sits beside a four-channel register file. The current addresses, the current counts and a 4-bit chain configuration word come in as flat vectors. One cycle later the unit returns the register set that the file should hold. It also raises a strobe when that set comes from a reload.

A reload starts from a single-cycle completion pulse from the transfer sequencer. The pulse names the channel that finished. The unit then supports two chain modes:

- **Four-channel mode:** all four descriptor slots rotate by one position. The count slot that the rotation vacates is cleared.
- **Two-channel mode:** the descriptor held in channel 3 is copied into the target channel.

Every move in a reload is taken from one snapshot of the inputs. The order of the moves therefore cannot corrupt a value.

Top module: `dma_chain_reload`

## Requirements
- R1: While `rst` is high, and at the first sample after it, `addr_o` and `cnt_o` are all zero and `reload_o` is low.
- R2: A `done_i` pulse with configuration bit 0 (chain enable) clear does not reload: `reload_o` stays low and the outputs repeat the inputs.
- R3: A `done_i` pulse while the count of channel `done_ch_i` is non-zero does not reload, even with chain enable set.
- R4: In every cycle without a reload, `addr_o` and `cnt_o` equal `addr_i` and `cnt_i` from the previous cycle.
- R5: Configuration bits [2:1] select the target channel. With bit 3 set (four-channel mode) the target is limited to 2. With bit 3 clear (two-channel mode) it is limited to 1.
- R6: In four-channel mode, with target t and indices taken mod 4, the addresses move as follows: slot t takes slot t+3, slot t+3 takes slot t+2, slot t+2 takes slot t+1, and slot t+1 takes the old slot t.
- R7: In four-channel mode the counts move in the same pattern as in R6, except that the count at slot t+1 becomes zero.
- R8: In two-channel mode, channel 3's address and count are copied into the target channel, and the other three channels are unchanged.
- R9: `reload_o` is high for exactly the one cycle in which the reloaded values first appear on `addr_o` and `cnt_o`. That is the cycle after the accepted pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| done_i | input | 1 | Completion pulse from the transfer sequencer |
| done_ch_i | input | 2 | Channel that completed |
| chain_cfg_i | input | 4 | Bit 0 chain enable, bits [2:1] target select, bit 3 four-channel mode |
| addr_i | input | 4*ADDR_W | Current address registers, channel n at bits [n*ADDR_W +: ADDR_W] |
| cnt_i | input | 4*CNT_W | Current count registers, channel n at bits [n*CNT_W +: CNT_W] |
| addr_o | output | 4*ADDR_W | Registered address set to write back |
| cnt_o | output | 4*CNT_W | Registered count set to write back |
| reload_o | output | 1 | One-cycle strobe marking a chain reload |

## Verification
Every output is registered from inputs sampled one cycle earlier, so an internal fault shows at the ports in the first cycle after the pulse that triggered it.

The observable symptoms of each fault are:
- **Wrong target cap:** puts the zeroed count, or the copied descriptor, in the wrong slot.
- **Rotation built in place instead of from a snapshot:** repeats one address in two slots.
- **Mis-decoded enable or terminal-count gate:** either fires `reload_o` on a pulse that should be ignored, or leaves the outputs mirroring the inputs when a reload was due.

The directed cases cover every select value in both modes, including the capped ones, so that each of these faults changes a compared slot.

// File: rtl/dcr_pkg.sv
`timescale 1ns/1ps
package dcr_pkg;
  localparam int NCH  = 4;
  localparam int CH_W = $clog2(NCH);

  // field order is decoded: mode at bit 3, select at [2:1], enable at bit 0
  typedef struct packed {
    logic            mode4;
    logic [CH_W-1:0] sel;
    logic            en;
  } chain_cfg_t;

  localparam logic [CH_W-1:0] CAP_FOUR = CH_W'(2);
  localparam logic [CH_W-1:0] CAP_TWO  = CH_W'(1);
endpackage

// File: rtl/dcr_target.sv
`timescale 1ns/1ps
module dcr_target
  import dcr_pkg::*;
(
  input  chain_cfg_t      cfg_i,
  output logic [CH_W-1:0] tgt_o,
  output logic [CH_W-1:0] vac_o
);
  logic [CH_W-1:0] cap;

  always_comb begin
    cap   = cfg_i.mode4 ? CAP_FOUR : CAP_TWO;
    tgt_o = (cfg_i.sel > cap) ? cap : cfg_i.sel;
    vac_o = tgt_o + 1'b1;
  end
endmodule

// File: rtl/dcr_permute.sv
`timescale 1ns/1ps
module dcr_permute
  import dcr_pkg::*;
#(
  parameter int W             = 16,
  parameter bit CLEAR_VACATED = 1'b0
) (
  input  logic [NCH*W-1:0] d_i,
  input  logic             mode4_i,
  input  logic [CH_W-1:0]  tgt_i,
  input  logic [CH_W-1:0]  vac_i,
  output logic [NCH*W-1:0] d_o
);
  logic [NCH-1:0][W-1:0] dv;
  logic [NCH-1:0][W-1:0] qv;

  assign dv  = d_i;
  assign d_o = qv;

  // four-channel rotation reduces to each slot taking its lower neighbour
  for (genvar i = 0; i < NCH; i++) begin : g_slot
    localparam int PREV = (i + NCH - 1) % NCH;
    logic [W-1:0] rot_val;
    logic [W-1:0] copy_val;

    if (CLEAR_VACATED) begin : g_clr
      assign rot_val = (vac_i == CH_W'(i)) ? '0 : dv[PREV];
    end else begin : g_keep
      assign rot_val = dv[PREV];
    end

    assign copy_val = (tgt_i == CH_W'(i)) ? dv[NCH-1] : dv[i];
    assign qv[i]    = mode4_i ? rot_val : copy_val;
  end
endmodule

// File: rtl/dma_chain_reload.sv
`timescale 1ns/1ps
module dma_chain_reload
  import dcr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  done_i,
  input  logic [CH_W-1:0]       done_ch_i,
  input  logic [3:0]            chain_cfg_i,
  input  logic [NCH*ADDR_W-1:0] addr_i,
  input  logic [NCH*CNT_W-1:0]  cnt_i,
  output logic [NCH*ADDR_W-1:0] addr_o,
  output logic [NCH*CNT_W-1:0]  cnt_o,
  output logic                  reload_o
);
  chain_cfg_t                 cfg;
  logic [NCH-1:0][CNT_W-1:0]  cnt_iv;
  logic [NCH-1:0][ADDR_W-1:0] addr_iv;
  logic [NCH-1:0][CNT_W-1:0]  cnt_ov;
  logic [NCH-1:0][ADDR_W-1:0] addr_ov;
  logic [CH_W-1:0]            tgt;
  logic [CH_W-1:0]            vac;
  logic [NCH*ADDR_W-1:0]      addr_nx;
  logic [NCH*CNT_W-1:0]       cnt_nx;
  logic                       at_term;
  logic                       fire;

  assign cfg     = chain_cfg_t'(chain_cfg_i);
  assign cnt_iv  = cnt_i;
  assign addr_iv = addr_i;
  assign cnt_ov  = cnt_o;
  assign addr_ov = addr_o;
  assign at_term = (cnt_iv[done_ch_i] == '0);
  assign fire    = done_i & cfg.en & at_term;

  dcr_target u_target (
    .cfg_i (cfg),
    .tgt_o (tgt),
    .vac_o (vac)
  );

  dcr_permute #(.W(ADDR_W), .CLEAR_VACATED(1'b0)) u_addr_perm (
    .d_i     (addr_i),
    .mode4_i (cfg.mode4),
    .tgt_i   (tgt),
    .vac_i   (vac),
    .d_o     (addr_nx)
  );

  dcr_permute #(.W(CNT_W), .CLEAR_VACATED(1'b1)) u_cnt_perm (
    .d_i     (cnt_i),
    .mode4_i (cfg.mode4),
    .tgt_i   (tgt),
    .vac_i   (vac),
    .d_o     (cnt_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_o   <= '0;
      cnt_o    <= '0;
      reload_o <= 1'b0;
    end else begin
      addr_o   <= fire ? addr_nx : addr_i;
      cnt_o    <= fire ? cnt_nx  : cnt_i;
      reload_o <= fire;
    end
  end

  // R2
  reload_cause_chk: assert property (@(posedge clk) disable iff (rst)
    reload_o |-> $past(done_i && chain_cfg_i[0]));

  // R3
  reload_term_chk: assert property (@(posedge clk) disable iff (rst)
    reload_o |-> $past(cnt_iv[done_ch_i]) == '0);

  // R4
  mirror_chk: assert property (@(posedge clk) disable iff (rst)
    (!reload_o && !$past(rst)) |-> (addr_o == $past(addr_i) && cnt_o == $past(cnt_i)));

  // R6
  rotate_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (reload_o && $past(chain_cfg_i[3])) |-> addr_ov[0] == $past(addr_iv[NCH-1]));

  // R7
  vacated_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (reload_o && $past(chain_cfg_i[3])) |-> cnt_ov[$past(vac)] == '0);

  // R8
  copy_chk: assert property (@(posedge clk) disable iff (rst)
    (reload_o && !$past(chain_cfg_i[3])) |->
      (addr_ov[$past(tgt)] == $past(addr_iv[NCH-1]) && cnt_ov[$past(tgt)] == $past(cnt_iv[NCH-1])));
endmodule

// File: tb/dma_chain_reload_bench.sv
`timescale 1ns/1ps
module dma_chain_reload_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        done_i = 1'b0;
  logic [1:0]  done_ch_i = '0;
  logic [3:0]  chain_cfg_i = '0;
  logic [63:0] addr_i = '0;
  logic [63:0] cnt_i = '0;
  logic [63:0] addr_o;
  logic [63:0] cnt_o;
  logic        reload_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [15:0] a [4];
  logic [15:0] c [4];
  logic [15:0] ea [4];
  logic [15:0] ec [4];

  always #2.5 clk = ~clk;

  dma_chain_reload u_dma_chain_reload (
    .clk(clk), .rst(rst), .done_i(done_i), .done_ch_i(done_ch_i),
    .chain_cfg_i(chain_cfg_i), .addr_i(addr_i), .cnt_i(cnt_i),
    .addr_o(addr_o), .cnt_o(cnt_o), .reload_o(reload_o)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fill(int seed, int zch);
    for (int i = 0; i < 4; i++) begin
      a[i] = 16'(16'h1000 * (i + 1) + seed);
      c[i] = 16'(16'h0010 * (i + 1) + seed + 1);
    end
    c[zch] = '0;
    for (int i = 0; i < 4; i++) begin
      addr_i[i*16 +: 16] = a[i];
      cnt_i[i*16 +: 16]  = c[i];
      ea[i] = a[i];
      ec[i] = c[i];
    end
  endtask

  task automatic pulse_and_check(string req, int ch, logic [3:0] cfg, bit exp_reload);
    @(negedge clk);
    done_ch_i   = 2'(ch);
    chain_cfg_i = cfg;
    done_i      = 1'b1;
    @(negedge clk);
    done_i = 1'b0;
    check({req, " reload"}, 16'(reload_o), 16'(exp_reload));
    for (int i = 0; i < 4; i++) begin
      check({req, " addr"}, addr_o[i*16 +: 16], ea[i]);
      check({req, " cnt"},  cnt_o[i*16 +: 16],  ec[i]);
    end
    @(negedge clk);
    // R9: strobe lasts one cycle
    check("R9 strobe drop", 16'(reload_o), 16'h0);
  endtask

  task automatic t_reset();
    check("R1 addr", addr_o[15:0], 16'h0);
    check("R1 cnt", cnt_o[63:48], 16'h0);
    check("R1 reload", 16'(reload_o), 16'h0);
  endtask

  task automatic t_no_enable();
    fill(3, 1);
    pulse_and_check("R2 R4 no enable", 1, 4'b1110, 1'b0);
  endtask

  task automatic t_nonzero();
    fill(5, 0);
    pulse_and_check("R3 nonzero count", 2, 4'b1001, 1'b0);
  endtask

  task automatic t_four(int sel);
    int t;
    fill(sel + 7, 2);
    t = (sel > 2) ? 2 : sel;
    ea[t]         = a[(t+3)%4];
    ea[(t+3)%4]   = a[(t+2)%4];
    ea[(t+2)%4]   = a[(t+1)%4];
    ea[(t+1)%4]   = a[t];
    ec[t]         = c[(t+3)%4];
    ec[(t+3)%4]   = c[(t+2)%4];
    ec[(t+2)%4]   = c[(t+1)%4];
    ec[(t+1)%4]   = '0;
    pulse_and_check("R5 R6 R7 R9 four", 2, {1'b1, 2'(sel), 1'b1}, 1'b1);
  endtask

  task automatic t_two(int sel);
    int t;
    fill(sel + 11, 3);
    c[3] = 16'h0042;
    cnt_i[63:48] = c[3];
    ec[3] = c[3];
    // completed channel must be at zero: use channel 0 or 1 set to zero
    c[sel % 2] = '0;
    cnt_i[(sel%2)*16 +: 16] = '0;
    ec[sel % 2] = '0;
    t = (sel > 1) ? 1 : sel;
    ea[t] = a[3];
    ec[t] = c[3];
    pulse_and_check("R5 R8 R9 two", sel % 2, {1'b0, 2'(sel), 1'b1}, 1'b1);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_no_enable();
    t_nonzero();
    for (int s = 0; s < 4; s++) t_four(s);
    for (int s = 0; s < 4; s++) t_two(s);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule